// File: doc/BRIEF.md
# Modem Status Loopback Generator

This block produces the modem status register of a serial controller while the controller runs in internal loopback. Each clock in which loopback is enabled, the four modem control outputs are copied onto the four modem status input positions in the register's upper nibble. A delta flag in the lower nibble records when a mirrored input changes.

The carrier detect, clear to send and data set ready deltas catch a change in either direction. The ring indicator delta catches only a falling ring line. The delta flags stay set until the register bank signals a read of the status register. That read-clear pulse wipes the whole register.

With loopback disabled, the external modem inputs are treated as held at zero. The register then changes only through the read-clear pulse.

Top module: `modem_loop_status`

## Requirements
- R1: While reset (active low) is asserted, and after it is released with no other stimulus, the status output is 0x00.
- R2: In a loopback cycle without read-clear, one clock later status bit 7 equals control bit 3, bit 6 equals control bit 2, bit 5 equals control bit 0, and bit 4 equals control bit 1.
- R3: In a loopback cycle without read-clear, a control value that differs from its current mirrored status bit sets the matching delta flag one clock later. Control bit 1 against status bit 4 sets flag bit 0. Control bit 0 against status bit 5 sets flag bit 1. Control bit 3 against status bit 7 sets flag bit 3.
- R4: Flag bit 2 is set only when control bit 2 is 0 while status bit 6 is 1, so a rising ring line sets nothing.
- R5: Once set, a delta flag stays set until a read-clear.
- R6: A read-clear pulse makes the whole status register 0x00 one clock later, whatever the loopback enable or the control inputs are in that cycle.
- R7: With loopback disabled and no read-clear, the status register holds its value whatever the control inputs do.
- R8: Control bits 7 to 4 have no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loopEn | input | 1 | Internal loopback enable |
| rdClr | input | 1 | One-cycle pulse from the register bank when the status register is read |
| modemCtrl | input | 8 | Modem control register contents |
| modemStat | output | 8 | Modem status register |

## Verification
Every result of this block appears one clock after the inputs that cause it. The status register is the only state between the inputs and the output. The bench therefore drives each stimulus on a falling edge, lets exactly one rising edge pass, and samples two nanoseconds later. The next stimulus is applied only after that sample, so each vector's expected value depends only on the previous vector's result and the new inputs.

// File: rtl/modem_loop_pkg.sv
package modem_loop_pkg;
  localparam int CTRL_W = 8;
  localparam int LINES  = 4;
  localparam int STAT_W = 2 * LINES;

  // Positions inside the status register.
  localparam int ST_DCTS = 0;
  localparam int ST_DDSR = 1;
  localparam int ST_TERI = 2;
  localparam int ST_DDCD = 3;
  localparam int ST_CTS  = 4;
  localparam int ST_DSR  = 5;
  localparam int ST_RI   = 6;
  localparam int ST_DCD  = 7;

  // Positions inside the control register.
  localparam int MC_DTR  = 0;
  localparam int MC_RTS  = 1;
  localparam int MC_AUX1 = 2;
  localparam int MC_AUX2 = 3;

  typedef struct packed {
    logic clearAll;
    logic mirror;
  } loopStrobe_t;
endpackage

// File: rtl/modem_loop_ctrl.sv
module modem_loop_ctrl
  import modem_loop_pkg::*;
(
  input  logic        loopEn,
  input  logic        rdClr,
  output loopStrobe_t strb
);
  always_comb begin
    strb.clearAll = rdClr;
    strb.mirror   = loopEn && !rdClr;
  end
endmodule

// File: rtl/modem_loop_dp.sv
module modem_loop_dp
  import modem_loop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  ctrlBits,
  input  loopStrobe_t       strb,
  output logic [STAT_W-1:0] stat
);
  logic [STAT_W-1:0] statQ;
  logic [LINES-1:0]  mirrorNext;
  logic [LINES-1:0]  deltaHit;

  always_comb begin
    mirrorNext[ST_CTS-LINES] = ctrlBits[MC_RTS];
    mirrorNext[ST_DSR-LINES] = ctrlBits[MC_DTR];
    mirrorNext[ST_RI-LINES]  = ctrlBits[MC_AUX1];
    mirrorNext[ST_DCD-LINES] = ctrlBits[MC_AUX2];

    deltaHit[ST_DCTS] = ctrlBits[MC_RTS]  != statQ[ST_CTS];
    deltaHit[ST_DDSR] = ctrlBits[MC_DTR]  != statQ[ST_DSR];
    deltaHit[ST_TERI] = !ctrlBits[MC_AUX1] && statQ[ST_RI];
    deltaHit[ST_DDCD] = ctrlBits[MC_AUX2] != statQ[ST_DCD];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAll) begin
      statQ <= '0;
    end else if (strb.mirror) begin
      statQ <= {mirrorNext, statQ[LINES-1:0] | deltaHit};
    end
  end

  assign stat = statQ;
endmodule

// File: rtl/modem_loop_status.sv
module modem_loop_status
  import modem_loop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loopEn,
  input  logic              rdClr,
  input  logic [CTRL_W-1:0] modemCtrl,
  output logic [STAT_W-1:0] modemStat
);
  loopStrobe_t strb;

  modem_loop_ctrl uCtrl (
    .loopEn (loopEn),
    .rdClr  (rdClr),
    .strb   (strb)
  );

  modem_loop_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlBits (modemCtrl[LINES-1:0]),
    .strb     (strb),
    .stat     (modemStat)
  );
endmodule

// File: rtl/modem_loop_status_chk.sv
module modem_loop_status_chk
  import modem_loop_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              loopEn,
  input logic              rdClr,
  input logic [CTRL_W-1:0] modemCtrl,
  input logic [STAT_W-1:0] modemStat
);
  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdClr |=> modemStat == '0);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!loopEn && !rdClr) |=> $stable(modemStat));

  assert_mirror_dcd_R2: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn && !rdClr) |=> modemStat[ST_DCD] == $past(modemCtrl[MC_AUX2]));

  assert_mirror_cts_R2: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn && !rdClr) |=> modemStat[ST_CTS] == $past(modemCtrl[MC_RTS]));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn && !rdClr) |=>
      ((modemStat[3:0] & $past(modemStat[3:0])) == $past(modemStat[3:0])));

  assert_ri_rise_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn && !rdClr && modemCtrl[MC_AUX1]) |=>
      modemStat[ST_TERI] == $past(modemStat[ST_TERI]));

  assert_cts_delta_R3: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn && !rdClr && (modemCtrl[MC_RTS] != modemStat[ST_CTS])) |=>
      modemStat[ST_DCTS]);
endmodule

bind modem_loop_status modem_loop_status_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .loopEn    (loopEn),
  .rdClr     (rdClr),
  .modemCtrl (modemCtrl),
  .modemStat (modemStat)
);

// File: tb/modem_loop_status_test.sv
`timescale 1ns/1ps
module modem_loop_status_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loopEn = 1'b0;
  logic       rdClr = 1'b0;
  logic [7:0] modemCtrl = 8'h00;
  logic [7:0] modemStat;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  modem_loop_status uut (
    .clk       (clk),
    .rstN      (rstN),
    .loopEn    (loopEn),
    .rdClr     (rdClr),
    .modemCtrl (modemCtrl),
    .modemStat (modemStat)
  );

  // {rdClr, loopEn, modemCtrl, expected status}
  localparam int NV = 16;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'hF0, 8'h00},  // R8 upper control bits ignored
    {1'b0, 1'b1, 8'h0F, 8'hFB},  // R2 R3 all lines rise, ring rise quiet
    {1'b0, 1'b1, 8'h0F, 8'hFB},  // R5 deltas sticky
    {1'b1, 1'b1, 8'h0F, 8'h00},  // R6 read-clear
    {1'b0, 1'b1, 8'h04, 8'h40},  // R4 ring rises, no delta
    {1'b0, 1'b1, 8'h00, 8'h04},  // R4 ring falls, trailing-edge flag
    {1'b1, 1'b0, 8'h00, 8'h00},  // R6 clear without loopback
    {1'b0, 1'b1, 8'h02, 8'h11},  // R3 cts only
    {1'b0, 1'b1, 8'h03, 8'h33},  // R3 dsr added
    {1'b0, 1'b1, 8'h0B, 8'hBB},  // R3 dcd added
    {1'b0, 1'b1, 8'h09, 8'hAB},  // R3 R5 cts falls, flag stays
    {1'b0, 1'b0, 8'h00, 8'hAB},  // R7 hold with loopback off
    {1'b0, 1'b0, 8'hFF, 8'hAB},  // R7 hold again
    {1'b1, 1'b0, 8'hFF, 8'h00},  // R6 clear
    {1'b1, 1'b1, 8'h0F, 8'h00},  // R6 clear wins over update
    {1'b0, 1'b1, 8'hAF, 8'hFB}   // R2 R8 update after clear
  };

  function automatic string vecTag(int i);
    case (i)
      0: return "R8";
      1: return "R2/R3";
      2: return "R5";
      3: return "R6";
      4: return "R4";
      5: return "R4";
      6: return "R6";
      7: return "R3";
      8: return "R3";
      9: return "R3";
      10: return "R5";
      11: return "R7";
      12: return "R7";
      13: return "R6";
      14: return "R6";
      default: return "R2/R8";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] exp);
    checks++;
    if (modemStat !== exp) begin
      fails++;
      $display("FAIL %s: modemStat=%02h expected %02h", tag, modemStat, exp);
    end
  endtask

  task automatic apply(logic clr, logic en, logic [7:0] ctl);
    @(negedge clk);
    rdClr = clr;
    loopEn = en;
    modemCtrl = ctl;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    modemCtrl = 8'h0F;
    loopEn = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1", 8'h00);
    @(negedge clk);
    loopEn = 1'b0;
    rstN = 1'b1;
    @(posedge clk);
    #2;
    check("R1", 8'h00);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][17], VEC[i][16], VEC[i][15:8]);
      check(vecTag(i), VEC[i][7:0]);
    end

    // R1: reset mid-run clears a loaded register
    apply(1'b0, 1'b1, 8'h0F);
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #2;
    check("R1", 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    loopEn = 1'b0;

    // R4: ring falls from a status of only ring set
    apply(1'b0, 1'b1, 8'h04);
    check("R4", 8'h40);
    apply(1'b0, 1'b1, 8'hF0);
    check("R4", 8'h04);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule